// File: doc/BRIEF.md
# Cascadable LCD Column Drive Register

This block is the digital core of a 40-column LCD segment driver. Serial column data arrives on two data inputs. Two independent 20-stage shift chains take that data on a common shift strobe. Each chain has its own serial output tap. With the taps left open, the two chains load side by side. Wiring the first tap to the second data input forms one 40-stage chain. Wiring the second tap to the first data input of a following copy extends the panel width.

A level-enabled column register captures all 40 stage values while its enable is high and holds them while it is low. For every column, the held bit and a frame-alternation input together produce a 2-bit code. The code selects one of four panel voltages. The mapping keeps the mean column voltage at zero over two frames.

All logic runs on one system clock. The shift strobe is an asynchronous-style level that the block samples; a shift happens on its sampled falling edge. The serial path has no valid/ready pair and cannot apply back-pressure. A falling edge of the shift strobe is the only qualifier for a data bit, and every such edge consumes one bit on each data input. The source must keep each strobe level for at least one system clock.

Top module: `lcd_seg_drv`

## Requirements
- R1: A synchronous active-high `rst` clears both shift chains and the column register to zero. After reset, with `frame_alt_i` = 0, every column code is 2'b10, and `dout_a_o` and `dout_b_o` are 0.
- R2: A shift event happens only at the first `clk` edge at which `shift_clk_i` is sampled 0 after being sampled 1. Both chains advance on the same event. With no event, neither tap output changes, and this includes a held low strobe and a rising strobe.
- R3: On each shift event, chain A takes `din_a_i` into stage 0. The bit taken by the n-th event appears on `dout_a_o` after event n+19, so it shows on the tap at the 20th event when its own event is counted.
- R4: Chain B behaves the same way on `din_b_i` and `dout_b_o`, with the same 20-event delay, and is independent of chain A.
- R5: With `dout_a_o` wired to `din_b_i`, the pair acts as one 40-stage chain. After 40 events, `dout_b_o` carries the first bit shifted in. After one more event, it carries the second bit.
- R6: Chain A stage k (stage 0 is the newest bit) drives column k+1. Chain B stage k drives column 21+k. Column c (1..40) owns bits [2c-1:2c-2] of `lvl_code_o`. A 20-event load of one chain therefore puts its first bit at column 20 (or column 40).
- R7: While `latch_en_i` is high, the column register copies the chain stages on every `clk` edge, one cycle behind the chains.
- R8: While `latch_en_i` is low, the column register holds its contents, and shifting does not alter `lvl_code_o`.
- R9: The column code is 2'b11 (VEE) for a held 1 with frame 0, and 2'b00 (VDD) for a held 1 with frame 1. It is 2'b10 (V3) for a held 0 with frame 0, and 2'b01 (V2) for a held 0 with frame 1. The code is combinational from the held bit and `frame_alt_i`.
- R10: When `frame_alt_i` changes and the column register does not, every column code becomes the bitwise complement of its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_clk_i | input | 1 | Shift strobe, sampled; its falling edge shifts both chains |
| latch_en_i | input | 1 | Column register enable, level sensitive |
| din_a_i | input | 1 | Serial data for columns 1..20 |
| din_b_i | input | 1 | Serial data for columns 21..40 |
| frame_alt_i | input | 1 | Frame alternation select |
| dout_a_o | output | 1 | Last stage of chain A |
| dout_b_o | output | 1 | Last stage of chain B (cascade output) |
| lvl_code_o | output | 80 | Two-bit drive code per column, column 1 in the low bits |

## Verification
On every cycle, the assertions check the following: the tap outputs move only on a sampled strobe fall, and each tap then takes its chain's next-to-last stage. The column register follows the chains while enabled and stays still while disabled. A frame change alone complements every code. Only the bench scenarios can show the full 20-event tap delay and the column placement of loaded patterns. They also show the 40-stage cascade formed through external wiring and the absolute value of each of the four codes.

// File: rtl/lcd_seg_pkg.sv
package lcd_seg_pkg;

  localparam int LVL_W = 2;

  typedef enum logic [LVL_W-1:0] {
    LVL_VDD = 2'b00,
    LVL_V2  = 2'b01,
    LVL_V3  = 2'b10,
    LVL_VEE = 2'b11
  } lvl_e;

  // Held-on columns swing between the outer rails, held-off columns between
  // the inner rails; the frame bit swaps polarity so the mean stays at zero.
  function automatic lvl_e drive_level(input logic seg_on, input logic frame);
    lvl_e lvl;
    unique case ({seg_on, frame})
      2'b10:   lvl = LVL_VEE;
      2'b11:   lvl = LVL_VDD;
      2'b00:   lvl = LVL_V3;
      default: lvl = LVL_V2;
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/lcd_strobe_edge.sv
module lcd_strobe_edge (
  input  logic clk,
  input  logic rst,
  input  logic strobe_i,
  output logic fall_o
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= strobe_i;
  end

  assign fall_o = prev_q & ~strobe_i;

endmodule

// File: rtl/lcd_shift_chain.sv
module lcd_shift_chain #(
  parameter int LEN = 20
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           adv_i,
  input  logic           din_i,
  output logic [LEN-1:0] q_o,
  output logic           dout_o
);

  always_ff @(posedge clk) begin
    if (rst)        q_o <= '0;
    else if (adv_i) q_o <= {q_o[LEN-2:0], din_i};
  end

  assign dout_o = q_o[LEN-1];

endmodule

// File: rtl/lcd_col_latch.sv
module lcd_col_latch #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk) begin
    if (rst)       q_o <= '0;
    else if (en_i) q_o <= d_i;
  end

endmodule

// File: rtl/lcd_lvl_map.sv
module lcd_lvl_map
  import lcd_seg_pkg::*;
#(
  parameter int NCOL = 40
) (
  input  logic                  frame_i,
  input  logic [NCOL-1:0]       seg_i,
  output logic [LVL_W*NCOL-1:0] code_o
);

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    assign code_o[c*LVL_W +: LVL_W] = drive_level(seg_i[c], frame_i);
  end

endmodule

// File: rtl/lcd_seg_drv.sv
module lcd_seg_drv
  import lcd_seg_pkg::*;
#(
  parameter  int CHAIN_LEN = 20,
  localparam int NCOL      = 2 * CHAIN_LEN
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  shift_clk_i,
  input  logic                  latch_en_i,
  input  logic                  din_a_i,
  input  logic                  din_b_i,
  input  logic                  frame_alt_i,
  output logic                  dout_a_o,
  output logic                  dout_b_o,
  output logic [LVL_W*NCOL-1:0] lvl_code_o
);

  localparam int NUM_CHAINS = NCOL / CHAIN_LEN;

  logic                  shift_ev;
  logic [NUM_CHAINS-1:0] din_vec;
  logic [NUM_CHAINS-1:0] dout_vec;
  logic [NCOL-1:0]       col_d;
  logic [NCOL-1:0]       lat_q;

  assign din_vec  = {din_b_i, din_a_i};
  assign dout_a_o = dout_vec[0];
  assign dout_b_o = dout_vec[NUM_CHAINS-1];

  lcd_strobe_edge u_edge (
    .clk      (clk),
    .rst      (rst),
    .strobe_i (shift_clk_i),
    .fall_o   (shift_ev)
  );

  for (genvar g = 0; g < NUM_CHAINS; g++) begin : g_chain
    lcd_shift_chain #(.LEN(CHAIN_LEN)) u_chain (
      .clk    (clk),
      .rst    (rst),
      .adv_i  (shift_ev),
      .din_i  (din_vec[g]),
      .q_o    (col_d[g*CHAIN_LEN +: CHAIN_LEN]),
      .dout_o (dout_vec[g])
    );
  end

  lcd_col_latch #(.W(NCOL)) u_latch (
    .clk  (clk),
    .rst  (rst),
    .en_i (latch_en_i),
    .d_i  (col_d),
    .q_o  (lat_q)
  );

  lcd_lvl_map #(.NCOL(NCOL)) u_map (
    .frame_i (frame_alt_i),
    .seg_i   (lat_q),
    .code_o  (lvl_code_o)
  );

endmodule

// File: rtl/lcd_seg_drv_chk.sv
module lcd_seg_drv_chk #(
  parameter int CHAIN_LEN = 20,
  parameter int NCOL      = 40
) (
  input logic              clk,
  input logic              rst,
  input logic              shift_clk_i,
  input logic              latch_en_i,
  input logic              frame_alt_i,
  input logic              dout_a_o,
  input logic              dout_b_o,
  input logic [2*NCOL-1:0] lvl_code_o,
  input logic [NCOL-1:0]   col_d,
  input logic [NCOL-1:0]   lat_q
);

  logic seen_high_q;
  logic fall_seen;

  always_ff @(posedge clk) begin
    if (rst) seen_high_q <= 1'b0;
    else     seen_high_q <= shift_clk_i;
  end

  assign fall_seen = seen_high_q && !shift_clk_i;

  // R2: taps stay put without a strobe fall
  assert_tap_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !fall_seen |=> ($stable(dout_a_o) && $stable(dout_b_o)));

  // R3: chain A tap takes its next-to-last stage on a shift
  assert_tap_a_step_R3: assert property (@(posedge clk) disable iff (rst)
    fall_seen |=> (dout_a_o == $past(col_d[CHAIN_LEN-2])));

  // R4: chain B tap takes its next-to-last stage on a shift
  assert_tap_b_step_R4: assert property (@(posedge clk) disable iff (rst)
    fall_seen |=> (dout_b_o == $past(col_d[NCOL-2])));

  // R7: enabled column register copies the chains
  assert_latch_follow_R7: assert property (@(posedge clk) disable iff (rst)
    latch_en_i |=> (lat_q == $past(col_d)));

  // R8: disabled column register holds
  assert_latch_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !latch_en_i |=> $stable(lat_q));

  // R10: frame change alone complements every code
  assert_frame_flip_R10: assert property (@(posedge clk) disable iff (rst)
    ((frame_alt_i != $past(frame_alt_i)) && $stable(lat_q))
      |-> (lvl_code_o == ~$past(lvl_code_o)));

endmodule

bind lcd_seg_drv lcd_seg_drv_chk #(.CHAIN_LEN(CHAIN_LEN), .NCOL(NCOL)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .shift_clk_i (shift_clk_i),
  .latch_en_i  (latch_en_i),
  .frame_alt_i (frame_alt_i),
  .dout_a_o    (dout_a_o),
  .dout_b_o    (dout_b_o),
  .lvl_code_o  (lvl_code_o),
  .col_d       (col_d),
  .lat_q       (lat_q)
);

// File: tb/lcd_seg_drv_tb_top.sv
module lcd_seg_drv_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int L  = 20;
  localparam int N  = 2 * L;
  localparam int CW = 2 * N;
  localparam int NVEC = 4;

  // vector layout: {pattern for columns 21..40, pattern for columns 1..20, frame}
  localparam logic [N:0] VEC [NVEC] = '{
    {20'hFFFFF, 20'h00000, 1'b0},
    {20'h00000, 20'hFFFFF, 1'b1},
    {20'hA5C3F, 20'h5A3C0, 1'b0},
    {20'h80001, 20'h12345, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0;
  logic len = 1'b0;
  logic dina = 1'b0;
  logic dinb_drv = 1'b0;
  logic frame = 1'b0;
  logic cascade = 1'b0;
  logic douta, doutb;
  logic dinb;
  logic [CW-1:0] lvl;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  assign dinb = cascade ? douta : dinb_drv;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_seg_drv dut_i (
    .clk         (clk),
    .rst         (rst),
    .shift_clk_i (sclk),
    .latch_en_i  (len),
    .din_a_i     (dina),
    .din_b_i     (dinb),
    .frame_alt_i (frame),
    .dout_a_o    (douta),
    .dout_b_o    (doutb),
    .lvl_code_o  (lvl)
  );

  task automatic chk(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R9 table applied per column; R6 bit positions
  function automatic logic [CW-1:0] exp_codes(input logic [N-1:0] bits, input logic m);
    logic [CW-1:0] e;
    for (int c = 0; c < N; c++)
      e[2*c +: 2] = bits[c] ? (m ? 2'b00 : 2'b11) : (m ? 2'b01 : 2'b10);
    return e;
  endfunction

  task automatic shift_bit(input logic a, input logic b);
    @(negedge clk); dina = a; dinb_drv = b; sclk = 1'b1;
    @(negedge clk);
    @(negedge clk); sclk = 1'b0;
    @(negedge clk);
  endtask

  task automatic load_split(input logic [L-1:0] pa, input logic [L-1:0] pb);
    for (int i = L-1; i >= 0; i--) shift_bit(pa[i], pb[i]);
  endtask

  task automatic pulse_latch();
    @(negedge clk); len = 1'b1;
    @(negedge clk); len = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [CW-1:0] prev;
    logic [N-1:0]  p;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 codes after reset", lvl, {N{2'b10}});
    chk("R1 taps after reset", {doutb, douta}, 2'b00);

    // vector table, split mode: R6, R9, R10
    for (int v = 0; v < NVEC; v++) begin
      load_split(VEC[v][L:1], VEC[v][N:L+1]);
      pulse_latch();
      @(negedge clk); frame = VEC[v][0];
      @(negedge clk);
      chk("R6/R9 split load codes", lvl, exp_codes(VEC[v][N:1], VEC[v][0]));
      prev = lvl;
      frame = ~frame;
      @(negedge clk);
      chk("R10 frame flip complement", lvl, ~prev);
      chk("R9 codes other frame", lvl, exp_codes(VEC[v][N:1], ~VEC[v][0]));
    end
    frame = 1'b0;

    // R3/R4 tap delay; chain B's marker enters one event later
    load_split('0, '0);
    shift_bit(1'b1, 1'b0);
    shift_bit(1'b0, 1'b1);
    for (int i = 0; i < 17; i++) shift_bit(1'b0, 1'b0);
    chk("R3 tap A before 20th event", douta, 1'b0);
    shift_bit(1'b0, 1'b0);
    chk("R3 tap A at 20th event", douta, 1'b1);
    chk("R4 tap B still low", doutb, 1'b0);
    shift_bit(1'b0, 1'b0);
    chk("R3 tap A after 21st event", douta, 1'b0);
    chk("R4 tap B at its 20th event", doutb, 1'b1);

    // R2: no shift on held-low or rising strobe
    repeat (5) @(negedge clk);
    chk("R2 tap B with strobe held low", doutb, 1'b1);
    sclk = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 tap B after rising strobe", doutb, 1'b1);
    sclk = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R2 tap B after falling strobe", doutb, 1'b0);

    // R8 hold while disabled, R7 follow when enabled
    load_split(20'h0F0F0, 20'hCCCCC);
    pulse_latch();
    prev = lvl;
    load_split(20'h3A3A3, 20'h11111);
    @(negedge clk);
    chk("R8 codes held while disabled", lvl, prev);
    pulse_latch();
    chk("R7 codes follow when enabled", lvl, exp_codes({20'h11111, 20'h3A3A3}, 1'b0));

    // R5 cascade through external wiring
    cascade = 1'b1;
    p = 40'hC3_5A96_1E7B;
    for (int i = N-1; i >= 0; i--) shift_bit(p[i], 1'b0);
    chk("R5 cascade tap after 40 events", doutb, p[N-1]);
    pulse_latch();
    chk("R5/R6 cascade column codes", lvl, exp_codes(p, 1'b0));
    shift_bit(1'b0, 1'b0);
    chk("R5 cascade tap after 41 events", doutb, p[N-2]);
    cascade = 1'b0;

    // R1 reset mid-operation
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 codes after second reset", lvl, {N{2'b10}});
    chk("R1 taps after second reset", {doutb, douta}, 2'b00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule